// File: doc/BRIEF.md
# Ethernet Transmit Framer with Jam

This block is the serial transmit path of a 10 Mbit/s MAC, run at one clock per bit. A host requests a frame with a request/acknowledge pair. Once an external access controller grants the start, the framer emits a one-cycle start pulse. It then sends a preamble of selectable length ending in the start-of-frame byte, followed by the host bytes least significant bit first. An optional frame check sequence (CRC-32) closes the frame, and it can be inverted on purpose so that the receiver sees a bad check.

Host bytes form a stream that the framer paces. `ld_req` is the ready strobe and it is a one-cycle pulse. There is no back-pressure from the host: `in_data` must be valid in the cycle `ld_req` is high, and it is captured at the clock edge that ends that cycle. The host marks the final byte with `in_last`, driven for the one cycle that follows that byte's `ld_req`. A collision reported by the access controller replaces the rest of the frame with a 32-bit jam of ones. A host abort cuts the frame short while still honouring the check-sequence settings.

Top module: `eth_tx_framer`

## Requirements
- R1: While reset is asserted, `tx_ack`, `sop`, `txen`, `txd`, `in_prog`, `ld_req`, `byte_sent` and `eop` are all 0.
- R2: `tx_ack` rises the cycle after `tx_req` is seen while idle, and falls the cycle after `tx_req` drops or at end of operation. Once `start_go` is seen, `sop` is high for one cycle, and the first preamble bit follows in the next cycle.
- R3: `pre_sel` sets the total preamble length, start-of-frame byte included: 0 gives 64 bits, 1 gives 56, 2 gives 48 and 3 gives 40. The bits alternate starting with 1, and the last two bits are both 1.
- R4: `ld_req` pulses for one cycle during the last preamble bit, then during bit 7 of every data byte except the last. Each captured byte is sent LSB first, starting in the next cycle.
- R5: `in_last` high at any clock edge during the data phase marks the byte in flight as the last one: no further `ld_req` follows it.
- R6: With `crc_append`=1, the data bits actually sent are followed by a 32-bit check. It is reflected polynomial 0x04C11DB7 with a preset of all ones, complemented, and sent LSB first. With `crc_append`=0, the frame ends after the data.
- R7: With `crc_invert`=1, the check register is sent without the final complement.
- R8: `byte_sent` pulses for one cycle right after the last bit of each data byte and each check byte, so an n-byte frame with the check gives n+4 pulses.
- R9: `col_in` high at an edge during data or check sends 32 ones from the next cycle. `in_prog` is low during the jam, and `txen` then drops.
- R10: `col_in` during the preamble lets the whole preamble finish, with no `ld_req`, and then the 32-bit jam follows.
- R11: `abort_in` during the preamble lets the preamble finish with no `ld_req`, and then applies the check settings over zero data bits.
- R12: `abort_in` at an edge during data ends data at that bit, and the check is then computed over the bits already sent.
- R13: `in_prog` is high exactly during preamble, data and check. `eop` pulses for one cycle, in the first cycle after `txen` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_req | input | 1 | Host frame request |
| tx_ack | output | 1 | Request accepted |
| start_go | input | 1 | Start grant from the access controller |
| col_in | input | 1 | Collision indication from the access controller |
| abort_in | input | 1 | Host abort |
| pre_sel | input | 2 | Preamble length select |
| crc_append | input | 1 | Append the check sequence |
| crc_invert | input | 1 | Send the check uncomplemented (forced bad) |
| ld_req | output | 1 | Byte load strobe (stream ready) |
| in_data | input | 8 | Host byte, valid while `ld_req` is high |
| in_last | input | 1 | Final-byte marker |
| sop | output | 1 | Start-of-packet pulse |
| txen | output | 1 | Transmit enable |
| txd | output | 1 | Serial data |
| in_prog | output | 1 | Preamble, data or check in progress |
| byte_sent | output | 1 | One byte finished |
| eop | output | 1 | End of operation pulse |

## Verification
The bench works through the corners where framing goes wrong. It exercises all four preamble lengths and a single-byte frame, where the last-byte marker lands in the first data bit. It also covers collisions in the preamble, in the data and inside the check, and aborts both in the preamble and mid-byte. A design that jammed straight away during the preamble would show a stream mismatch, and so would one that folded a truncated byte into the check or dropped the final complement. A stray load request after the marker would show up as a wrong `ld_req` count. A strobe raised for jam or preamble bytes would break the `byte_sent` count.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ARMED, S_SOP, S_PRE, S_DATA, S_FCS, S_JAM, S_EOP
  } tx_state_e;

  localparam int          FCS_BITS      = 32;
  localparam logic [31:0] FCS_POLY_REFL = 32'hEDB88320;

  // total preamble bits including the start-of-frame byte
  function automatic logic [6:0] pre_total(input logic [1:0] sel);
    return 7'd64 - {2'b00, sel, 3'b000};
  endfunction
endpackage

// File: rtl/eth_tx_fcs.sv
module eth_tx_fcs
  import eth_tx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                en,
  input  logic                bit_in,
  input  logic                invert,
  output logic [FCS_BITS-1:0] fcs
);
  logic [FCS_BITS-1:0] crc_q, crc_step, crc_d;

  assign crc_step = {1'b0, crc_q[FCS_BITS-1:1]} ^
                    ((crc_q[0] ^ bit_in) ? FCS_POLY_REFL : '0);
  // value including the bit on the wire this cycle
  assign crc_d = en ? crc_step : crc_q;
  assign fcs   = invert ? crc_d : ~crc_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc_q <= '1;
    else if (clr) crc_q <= '1;
    else if (en)  crc_q <= crc_step;
  end
endmodule

// File: rtl/eth_tx_shift.sv
module eth_tx_shift #(
  parameter int DATA_W = 8,
  parameter int SH_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_byte,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              load_fcs,
  input  logic [SH_W-1:0]   fcs_in,
  input  logic              shift,
  output logic              bit_out
);
  logic [SH_W-1:0] sh_q;

  assign bit_out = sh_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sh_q <= '0;
    else if (load_fcs)  sh_q <= fcs_in;
    else if (load_byte) sh_q <= SH_W'(byte_in);
    else if (shift)     sh_q <= {1'b0, sh_q[SH_W-1:1]};
  end
endmodule

// File: rtl/eth_tx_ctrl.sv
module eth_tx_ctrl
  import eth_tx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int JAM_BITS = 32,
  parameter int CNT_W    = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_req,
  input  logic       start_go,
  input  logic       col_in,
  input  logic       abort_in,
  input  logic       in_last,
  input  logic [1:0] pre_sel,
  input  logic       crc_append,
  output logic       tx_ack,
  output logic       sop,
  output logic       txen,
  output logic       in_prog,
  output logic       ld_req,
  output logic       byte_sent,
  output logic       eop,
  output logic       ph_pre,
  output logic       ph_shift,
  output logic       ph_jam,
  output logic       pre_bit,
  output logic       crc_clr,
  output logic       crc_en,
  output logic       ld_fcs
);
  localparam int IDX_W = $clog2(DATA_W);

  tx_state_e        st_q, nxt;
  logic [CNT_W-1:0] cnt_q, pre_end;
  logic             col_q, abt_q, last_q, ack_q, bsent_q;
  logic             pre_last, idx_last, fcs_last, jam_last;

  assign pre_end  = CNT_W'(pre_total(pre_sel)) - CNT_W'(1);
  assign pre_last = (cnt_q == pre_end);
  assign idx_last = (cnt_q[IDX_W-1:0] == IDX_W'(DATA_W-1));
  assign fcs_last = (cnt_q == CNT_W'(FCS_BITS-1));
  assign jam_last = (cnt_q == CNT_W'(JAM_BITS-1));

  always_comb begin
    nxt = st_q;
    unique case (st_q)
      S_IDLE:  if (tx_req) nxt = S_ARMED;
      S_ARMED: if (start_go) nxt = S_SOP;
      S_SOP:   nxt = S_PRE;
      S_PRE: if (pre_last) begin
        if (col_q || col_in)          nxt = S_JAM;
        else if (abt_q || abort_in)   nxt = crc_append ? S_FCS : S_EOP;
        else                          nxt = S_DATA;
      end
      S_DATA: begin
        if (col_in)                    nxt = S_JAM;
        else if (abort_in)             nxt = crc_append ? S_FCS : S_EOP;
        else if (idx_last && last_q)   nxt = crc_append ? S_FCS : S_EOP;
      end
      S_FCS: begin
        if (col_in)        nxt = S_JAM;
        else if (fcs_last) nxt = S_EOP;
      end
      S_JAM:   if (jam_last) nxt = S_EOP;
      S_EOP:   nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      cnt_q   <= '0;
      col_q   <= 1'b0;
      abt_q   <= 1'b0;
      last_q  <= 1'b0;
      ack_q   <= 1'b0;
      bsent_q <= 1'b0;
    end else begin
      st_q    <= nxt;
      cnt_q   <= (nxt != st_q) ? '0 : cnt_q + CNT_W'(1);
      col_q   <= (st_q == S_SOP) ? 1'b0 : (col_q  | (st_q == S_PRE  && col_in));
      abt_q   <= (st_q == S_SOP) ? 1'b0 : (abt_q  | (st_q == S_PRE  && abort_in));
      last_q  <= (st_q == S_SOP) ? 1'b0 : (last_q | (st_q == S_DATA && in_last));
      ack_q   <= tx_req && (st_q == S_IDLE || (ack_q && st_q != S_EOP));
      bsent_q <= (st_q == S_DATA || st_q == S_FCS) && idx_last;
    end
  end

  assign ph_pre    = (st_q == S_PRE);
  assign ph_shift  = (st_q == S_DATA) || (st_q == S_FCS);
  assign ph_jam    = (st_q == S_JAM);
  assign pre_bit   = pre_last | ~cnt_q[0];
  assign tx_ack    = ack_q;
  assign sop       = (st_q == S_SOP);
  assign eop       = (st_q == S_EOP);
  assign in_prog   = ph_pre || ph_shift;
  assign txen      = in_prog || ph_jam;
  assign byte_sent = bsent_q;
  assign ld_req    = (ph_pre && pre_last && !col_q && !abt_q) ||
                     (st_q == S_DATA && idx_last && !last_q);
  assign crc_clr   = sop;
  assign crc_en    = (st_q == S_DATA);
  assign ld_fcs    = (nxt == S_FCS) && (st_q != S_FCS);
endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer
  import eth_tx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int JAM_BITS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_req,
  output logic              tx_ack,
  input  logic              start_go,
  input  logic              col_in,
  input  logic              abort_in,
  input  logic [1:0]        pre_sel,
  input  logic              crc_append,
  input  logic              crc_invert,
  output logic              ld_req,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              sop,
  output logic              txen,
  output logic              txd,
  output logic              in_prog,
  output logic              byte_sent,
  output logic              eop
);
  localparam int SPAN  = (JAM_BITS > 64) ? JAM_BITS : 64;
  localparam int CNT_W = $clog2(SPAN) + 1;

  logic                ph_pre, ph_shift, ph_jam, pre_bit;
  logic                crc_clr, crc_en, ld_fcs, sh_bit;
  logic [FCS_BITS-1:0] fcs;

  eth_tx_ctrl #(.DATA_W(DATA_W), .JAM_BITS(JAM_BITS), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .start_go(start_go),
    .col_in(col_in), .abort_in(abort_in), .in_last(in_last),
    .pre_sel(pre_sel), .crc_append(crc_append), .tx_ack(tx_ack),
    .sop(sop), .txen(txen), .in_prog(in_prog), .ld_req(ld_req),
    .byte_sent(byte_sent), .eop(eop), .ph_pre(ph_pre), .ph_shift(ph_shift),
    .ph_jam(ph_jam), .pre_bit(pre_bit), .crc_clr(crc_clr), .crc_en(crc_en),
    .ld_fcs(ld_fcs)
  );

  eth_tx_fcs u_fcs (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en),
    .bit_in(sh_bit), .invert(crc_invert), .fcs(fcs)
  );

  eth_tx_shift #(.DATA_W(DATA_W), .SH_W(FCS_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .load_byte(ld_req), .byte_in(in_data),
    .load_fcs(ld_fcs), .fcs_in(fcs), .shift(ph_shift), .bit_out(sh_bit)
  );

  always_comb begin
    if (ph_jam)        txd = 1'b1;
    else if (ph_pre)   txd = pre_bit;
    else if (ph_shift) txd = sh_bit;
    else               txd = 1'b0;
  end
endmodule

// File: rtl/eth_tx_framer_chk.sv
module eth_tx_framer_chk (
  input logic clk,
  input logic rst_n,
  input logic sop,
  input logic txen,
  input logic txd,
  input logic in_prog,
  input logic ld_req,
  input logic byte_sent,
  input logic eop
);
  // R2
  sop_then_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sop |=> (!sop && txen));
  // R4
  ld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_req |=> !ld_req);
  // R8
  bsent_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_sent |=> !byte_sent);
  // R9
  jam_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txen && !in_prog) |-> txd);
  // R13
  prog_within_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_prog |-> txen);
  // R13
  eop_after_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txen) |-> eop);
  // R13
  eop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eop |=> !eop);
endmodule

bind eth_tx_framer eth_tx_framer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sop(sop), .txen(txen), .txd(txd),
  .in_prog(in_prog), .ld_req(ld_req), .byte_sent(byte_sent), .eop(eop)
);

// File: tb/eth_tx_framer_bench.sv
module eth_tx_framer_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, tx_req, start_go, col_in, abort_in, in_last;
  logic       crc_append, crc_invert;
  logic [1:0] pre_sel;
  logic [7:0] in_data;
  logic       tx_ack, ld_req, sop, txen, txd, in_prog, byte_sent, eop;

  eth_tx_framer u_eth_tx_framer (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .tx_ack(tx_ack),
    .start_go(start_go), .col_in(col_in), .abort_in(abort_in),
    .pre_sel(pre_sel), .crc_append(crc_append), .crc_invert(crc_invert),
    .ld_req(ld_req), .in_data(in_data), .in_last(in_last), .sop(sop),
    .txen(txen), .txd(txd), .in_prog(in_prog), .byte_sent(byte_sent),
    .eop(eop)
  );

  int checks = 0, fails = 0;
  bit exp_q[$];
  int nonjam, mon_idx, bit_err, prog_err;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(int s, int k);
    return 8'((k * 53 + s * 29 + 7) ^ (k << 3));
  endfunction

  // monitor: pops the expected serial stream while txen is high
  always @(negedge clk) begin
    if (rst_n && txen) begin
      if (exp_q.size() == 0) bit_err++;
      else if (exp_q.pop_front() !== txd) bit_err++;
      if (in_prog !== (mon_idx < nonjam)) prog_err++;
      mon_idx++;
    end
  end

  // driver: builds the expected stream, then runs one frame
  task automatic run_frame(int sel, int n, bit app, bit inv, int col_c,
                           int abt_c, int seed, string tag);
    int L, dbits, cut, exp_bs, exp_ld, k, txc, nbs, nld, neop;
    bit tmp[$];
    bit pre_col, pre_abt, last_arm, done, first;
    logic [31:0] crc, fcs;
    logic [7:0] bv;
    L = 64 - 8 * sel;
    exp_q.delete();
    for (int i = 0; i < L; i++) exp_q.push_back((i == L - 1) ? 1'b1 : (i % 2 == 0));
    pre_col = (col_c >= 0) && (col_c < L);
    pre_abt = (abt_c >= 0) && (abt_c < L);
    crc = 32'hFFFFFFFF;
    if (!pre_col) begin
      dbits = pre_abt ? 0 : ((abt_c >= L) ? abt_c - L + 1 : 8 * n);
      for (int j = 0; j < dbits; j++) begin
        bv = byte_of(seed, j / 8);
        tmp.push_back(bv[j % 8]);
        crc = (crc[0] ^ bv[j % 8]) ? ((crc >> 1) ^ 32'hEDB88320) : (crc >> 1);
      end
      if (app) begin
        fcs = inv ? crc : ~crc;
        for (int j = 0; j < 32; j++) tmp.push_back(fcs[j]);
      end
    end
    if (pre_col) begin
      nonjam = L; exp_bs = 0;
      for (int j = 0; j < 32; j++) exp_q.push_back(1'b1);
    end else if (col_c >= L) begin
      cut = col_c - L + 1;
      for (int j = 0; j < cut; j++) exp_q.push_back(tmp[j]);
      for (int j = 0; j < 32; j++) exp_q.push_back(1'b1);
      nonjam = col_c + 1; exp_bs = cut / 8;
    end else begin
      for (int j = 0; j < tmp.size(); j++) exp_q.push_back(tmp[j]);
      nonjam = L + tmp.size(); exp_bs = tmp.size() / 8;
    end
    exp_ld = (pre_col || pre_abt) ? 0 : ((col_c >= L || abt_c >= L) ? -1 : n);

    pre_sel = 2'(sel); crc_append = app; crc_invert = inv;
    bit_err = 0; prog_err = 0; mon_idx = 0;
    tx_req = 1'b1;
    @(negedge clk);
    chk(tx_ack === 1'b1, {tag, " R2 ack rise"}, int'(tx_ack), 1);
    tx_req = 1'b0; start_go = 1'b1;
    @(negedge clk);
    chk(sop === 1'b1 && tx_ack === 1'b0, {tag, " R2 sop with ack drop"},
        int'({sop, tx_ack}), 2);
    start_go = 1'b0;
    k = 0; txc = 0; nbs = 0; nld = 0; neop = 0; last_arm = 0; done = 0; first = 1;
    while (!done) begin
      @(negedge clk);
      if (first) chk(txen === 1'b1, {tag, " R2 first bit after sop"}, int'(txen), 1);
      first = 0;
      if (byte_sent) nbs++;
      if (ld_req) nld++;
      if (eop) begin neop++; done = 1; end
      in_last = last_arm; last_arm = 0;
      if (ld_req) begin
        in_data = byte_of(seed, k);
        if (k == n - 1) last_arm = 1;
        k++;
      end
      col_in   = txen && (txc == col_c);
      abort_in = txen && (txc == abt_c);
      if (txen) txc++;
    end
    in_last = 1'b0; col_in = 1'b0; abort_in = 1'b0;
    @(negedge clk);
    chk(bit_err == 0 && exp_q.size() == 0, {tag, " serial stream"},
        bit_err + exp_q.size(), 0);
    chk(prog_err == 0, {tag, " R13 in_prog span"}, prog_err, 0);
    chk(nbs == exp_bs, {tag, " R8 byte_sent count"}, nbs, exp_bs);
    if (exp_ld >= 0) chk(nld == exp_ld, {tag, " R4 R5 ld_req count"}, nld, exp_ld);
    chk(eop === 1'b0 && txen === 1'b0 && neop == 1, {tag, " R13 eop single pulse"},
        neop, 1);
  endtask

  initial begin
    #600000;
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tx_req = 1'b0; start_go = 1'b0; col_in = 1'b0;
    abort_in = 1'b0; in_last = 1'b0; crc_append = 1'b0; crc_invert = 1'b0;
    pre_sel = 2'd0; in_data = 8'd0; nonjam = 0; mon_idx = 0;
    bit_err = 0; prog_err = 0;
    repeat (3) @(negedge clk);
    chk({tx_ack, sop, txen, txd, in_prog, ld_req, byte_sent, eop} === 8'd0,
        "R1 reset outputs", int'({tx_ack, sop, txen, txd, in_prog, ld_req, byte_sent, eop}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_frame(0, 4, 1, 0, -1, -1, 1, "R3 R4 R6 sel0");
    run_frame(1, 3, 0, 0, -1, -1, 2, "R3 R6 sel1 no-append");
    run_frame(2, 5, 1, 1, -1, -1, 3, "R3 R7 sel2 inverted");
    run_frame(3, 1, 1, 0, -1, -1, 4, "R3 R5 sel3 one-byte");
    run_frame(3, 3, 1, 0, 10, -1, 5, "R10 col in preamble");
    run_frame(0, 2, 1, 0, 5, -1, 6, "R10 early col");
    run_frame(0, 4, 1, 0, 64 + 13, -1, 7, "R9 col in data");
    run_frame(3, 2, 1, 0, 40 + 16 + 5, -1, 8, "R9 col in check");
    run_frame(1, 3, 1, 0, -1, 5, 9, "R11 abort in preamble");
    run_frame(0, 4, 1, 1, -1, 64 + 20, 10, "R12 abort in data");
    run_frame(2, 2, 0, 0, -1, 48 + 9, 11, "R12 abort no-append");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule